// File: doc/BRIEF.md
# Boot Entry Sequence Detector

This block decides where a processor begins fetching once its external reset is let go. It watches two asynchronous board pins: an active-low reset request and a test-mode pin. Both pins pass through multi-flop synchronisers, and all edge detection works on the synchronised copies. While the reset pin is held low, the block counts rising edges on the test pin. The count saturates at the qualifying number.

When the synchronised reset pin rises, the block looks at two things: the edge count, and the level the test pin still has at that moment. With at least the required number of edges and the test pin still high, it selects the boot-loader entry address. In every other case it selects the normal reset-vector location. It then raises a one-clock start strobe and holds the chosen address steady until the next release.

The block also drives a debug-select flag that follows the synchronised test pin. The pin-sharing logic uses this flag to hand four port pins over to the debug interface.

Top module: `boot_entry_detect`

## Requirements
- R1: Each pin passes through SYNC_STAGES (default 2) flops clocked by `clk` before any logic uses it. A level change on `test_pin` applied between clock edges appears on `debug_sel` after exactly two rising clock edges.
- R2: Rising edges on `test_pin` are counted only while the synchronised `rst_pin_n` is low. Edges that arrive while it is high do not count towards boot entry.
- R3: The edge count returns to zero whenever the synchronised `rst_pin_n` is high, so each low phase of the reset pin starts counting from zero.
- R4: The edge count saturates at EDGES_REQ (default 2). Further edges never make it exceed that value, and they never disqualify entry.
- R5: If at least EDGES_REQ edges were counted during the low phase and the synchronised `test_pin` is high in the cycle that sees the rise of the synchronised `rst_pin_n`, then `start_addr` becomes BOOT_ADDR (default 16'h0C00).
- R6: In every other release case `start_addr` becomes VECTOR_ADDR (default 16'hFFFE, the normal reset-vector location). This includes fewer edges, a test pin that is low at release, or edges seen only outside the low phase.
- R7: `start_pulse` is high for exactly one clock per release. It rises in the clock after the synchronised `rst_pin_n` rises, which is three rising edges after the pin change. It never rises at any other time.
- R8: `start_addr` changes only together with `start_pulse` and otherwise holds its value. After `por_n` it reads VECTOR_ADDR, with `start_pulse` and `debug_sel` low.
- R9: `debug_sel` is high exactly while the synchronised `test_pin` is high, independent of the reset pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| test_pin | input | 1 | Asynchronous test-mode pin |
| rst_pin_n | input | 1 | Asynchronous active-low external reset pin |
| start_pulse | output | 1 | One-clock strobe: begin fetching from `start_addr` |
| start_addr | output | 16 | Selected start address, held between strobes |
| debug_sel | output | 1 | High while the shared pins belong to the debug interface |

## Verification
The embedded properties check the following on every cycle:
- The edge count never passes its saturation value.
- The edge count is clear after any cycle with the reset pin high, and it holds when no edge arrives.
- The strobe never lasts two cycles.
- The address moves only with the strobe.
- A strobe always follows a reset-pin high level three clocks earlier.
- A release with the test pin low always selects the vector address.
- `debug_sel` echoes the test pin two clocks late.

The bench scenarios cover the behaviours the properties cannot show. It sweeps the number of test-pin edges and the test-pin level at release to confirm the boot/vector choice and the exact strobe latency. It also shows that edges outside the low phase, or in an earlier low phase, never qualify, and that the total number of strobes equals the number of releases.

// File: rtl/boot_entry_pkg.sv
package boot_entry_pkg;

   // Outcome of one reset-release decision
   typedef enum logic [0:0] {
      START_VECTOR = 1'b0,
      START_BOOT   = 1'b1
   } start_kind_e;

   // Width needed to hold a saturating count up to limit
   function automatic int unsigned count_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/bed_pin_sync.sv
// Multi-stage synchroniser with a registered copy of its output for edge detection
module bed_pin_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin,
   output logic level,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("bed_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              level_prev_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         chain_q      <= {STAGES{RESET_VAL}};
         level_prev_q <= RESET_VAL;
      end else begin
         chain_q      <= {chain_q[STAGES-2:0], pin};
         level_prev_q <= chain_q[STAGES-1];
      end
   end

   assign level = chain_q[STAGES-1];
   assign rise  = level & ~level_prev_q;

endmodule

// File: rtl/bed_edge_counter.sv
// Saturating count of qualifying edges, cleared while the clear input is high
module bed_edge_counter
   import boot_entry_pkg::*;
#(
   parameter int unsigned EDGES_REQ = 2,
   localparam int unsigned CNT_W    = count_width(EDGES_REQ)
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             clr,
   input  logic             edge_seen,
   output logic [CNT_W-1:0] count,
   output logic             qualified
);

   if (EDGES_REQ < 1) begin : g_bad_req
      $error("bed_edge_counter: EDGES_REQ must be at least 1");
   end

   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(EDGES_REQ);

   logic [CNT_W-1:0] count_q;

   if (EDGES_REQ == 1) begin : g_flag
      // A single edge qualifies: a sticky flag is enough
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)         count_q <= '0;
         else if (clr)       count_q <= '0;
         else if (edge_seen) count_q <= LIMIT;
      end
   end else begin : g_counter
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                            count_q <= '0;
         else if (clr)                          count_q <= '0;
         else if (edge_seen && count_q < LIMIT) count_q <= count_q + 1'b1;
      end
   end

   assign count     = count_q;
   assign qualified = (count_q >= LIMIT);

   // R4: saturation
   a_r4_count_saturates: assert property (@(posedge clk) disable iff (!por_n)
      count_q <= LIMIT);
   // R3: a high reset pin leaves the count at zero
   a_r3_clear_when_high: assert property (@(posedge clk) disable iff (!por_n)
      clr |=> count_q == '0);
   // R2: the count only moves on a counted edge
   a_r2_hold_without_edge: assert property (@(posedge clk) disable iff (!por_n)
      (!clr && !edge_seen) |=> $stable(count_q));

endmodule

// File: rtl/bed_start_ctrl.sv
// Picks the start address at reset release and issues the one-cycle strobe
module bed_start_ctrl
   import boot_entry_pkg::*;
#(
   parameter int unsigned        ADDR_W      = 16,
   parameter logic [ADDR_W-1:0]  BOOT_ADDR   = 16'h0C00,
   parameter logic [ADDR_W-1:0]  VECTOR_ADDR = 16'hFFFE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              release_seen,
   input  logic              test_level,
   input  logic              qualified,
   output logic              start_pulse,
   output logic [ADDR_W-1:0] start_addr
);

   if (ADDR_W < 1) begin : g_bad_width
      $error("bed_start_ctrl: ADDR_W must be positive");
   end

   start_kind_e       kind;
   logic              pulse_q;
   logic [ADDR_W-1:0] addr_q;

   always_comb begin
      kind = START_VECTOR;
      if (qualified && test_level) kind = START_BOOT;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pulse_q <= 1'b0;
         addr_q  <= VECTOR_ADDR;
      end else begin
         pulse_q <= release_seen;
         if (release_seen)
            addr_q <= (kind == START_BOOT) ? BOOT_ADDR : VECTOR_ADDR;
      end
   end

   assign start_pulse = pulse_q;
   assign start_addr  = addr_q;

   // R7: strobe never lasts more than a cycle
   a_r7_single_cycle: assert property (@(posedge clk) disable iff (!por_n)
      pulse_q |=> !pulse_q);
   // R8: address moves only with the strobe
   a_r8_addr_holds: assert property (@(posedge clk) disable iff (!por_n)
      !pulse_q |-> addr_q == $past(addr_q));
   // R5/R6: only the two legal addresses appear with the strobe
   a_r5_legal_addr: assert property (@(posedge clk) disable iff (!por_n)
      pulse_q |-> (addr_q == BOOT_ADDR || addr_q == VECTOR_ADDR));

endmodule

// File: rtl/boot_entry_detect.sv
module boot_entry_detect
   import boot_entry_pkg::*;
#(
   parameter int unsigned       SYNC_STAGES = 2,
   parameter int unsigned       EDGES_REQ   = 2,
   parameter int unsigned       ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] BOOT_ADDR   = 16'h0C00,
   parameter logic [ADDR_W-1:0] VECTOR_ADDR = 16'hFFFE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              test_pin,
   input  logic              rst_pin_n,
   output logic              start_pulse,
   output logic [ADDR_W-1:0] start_addr,
   output logic              debug_sel
);

   localparam int unsigned CNT_W = count_width(EDGES_REQ);

   logic             test_lvl, test_rise;
   logic             rst_lvl, rst_rise;
   logic [CNT_W-1:0] edge_count;
   logic             qualified;

   bed_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_test_sync (
      .clk(clk), .por_n(por_n), .pin(test_pin), .level(test_lvl), .rise(test_rise));

   bed_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_rst_sync (
      .clk(clk), .por_n(por_n), .pin(rst_pin_n), .level(rst_lvl), .rise(rst_rise));

   bed_edge_counter #(.EDGES_REQ(EDGES_REQ)) u_counter (
      .clk(clk), .por_n(por_n),
      .clr(rst_lvl),
      .edge_seen(test_rise & ~rst_lvl),
      .count(edge_count),
      .qualified(qualified));

   bed_start_ctrl #(.ADDR_W(ADDR_W), .BOOT_ADDR(BOOT_ADDR), .VECTOR_ADDR(VECTOR_ADDR)) u_ctrl (
      .clk(clk), .por_n(por_n),
      .release_seen(rst_rise),
      .test_level(test_lvl),
      .qualified(qualified),
      .start_pulse(start_pulse),
      .start_addr(start_addr));

   assign debug_sel = test_lvl;

   // R9/R1: debug flag echoes the pin after the synchroniser
   if (SYNC_STAGES == 2) begin : g_sync2_checks
      a_r9_debug_follows_pin: assert property (@(posedge clk) disable iff (!por_n)
         debug_sel |-> $past(test_pin, 2));
      // R7: a strobe follows a high reset pin
      a_r7_strobe_after_release: assert property (@(posedge clk) disable iff (!por_n)
         start_pulse |-> $past(rst_pin_n, 3));
      // R6: test pin low at release selects the vector
      a_r6_low_test_vector: assert property (@(posedge clk) disable iff (!por_n)
         (start_pulse && !$past(test_pin, 3)) |-> start_addr == VECTOR_ADDR);
   end

endmodule

// File: tb/boot_entry_detect_bench.sv
module boot_entry_detect_bench;

   localparam logic [15:0] BOOT = 16'h0C00;
   localparam logic [15:0] VEC  = 16'hFFFE;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        test_pin = 1'b0;
   logic        rst_pin_n = 1'b0;
   logic        start_pulse;
   logic [15:0] start_addr;
   logic        debug_sel;

   int checks = 0;
   int fails = 0;
   int pulses_seen = 0;
   int releases = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   boot_entry_detect u_boot_entry_detect (
      .clk(clk), .por_n(por_n), .test_pin(test_pin), .rst_pin_n(rst_pin_n),
      .start_pulse(start_pulse), .start_addr(start_addr), .debug_sel(debug_sel));

   always @(negedge clk) if (por_n && start_pulse) pulses_seen++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic test_pulse();
      test_pin = 1'b1; wait_neg(3);
      test_pin = 1'b0; wait_neg(3);
   endtask

   // raise reset pin at a negedge, check strobe timing and address
   task automatic release_check(input string req, input logic [15:0] exp);
      rst_pin_n = 1'b1;
      releases++;
      wait_neg(2);
      check({req, " R7 no early strobe"}, start_pulse, 1'b0);
      wait_neg(1);
      check({req, " R7 strobe"}, start_pulse, 1'b1);
      check(req, start_addr, exp);
      wait_neg(1);
      check({req, " R7 strobe one cycle"}, start_pulse, 1'b0);
      check({req, " R8 addr held"}, start_addr, exp);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      wait_neg(3);
      por_n = 1'b1;
      wait_neg(2);
      // R8 reset state
      check("R8 reset pulse", start_pulse, 1'b0);
      check("R8 reset addr", start_addr, VEC);
      check("R9 reset debug", debug_sel, 1'b0);

      // R1/R9: debug flag latency
      test_pin = 1'b1;
      wait_neg(1);
      check("R1 debug after one edge", debug_sel, 1'b0);
      wait_neg(1);
      check("R1 debug after two edges", debug_sel, 1'b1);
      test_pin = 1'b0;
      wait_neg(3);
      check("R9 debug low", debug_sel, 1'b0);

      // R4/R5/R6 sweep: n full pulses then optional final high level
      for (int n = 0; n < 5; n++) begin
         for (int fin = 0; fin < 2; fin++) begin
            int edges;
            logic [15:0] exp;
            edges = n + fin;
            exp = (edges >= 2 && fin == 1) ? BOOT : VEC;
            for (int k = 0; k < n; k++) test_pulse();
            if (fin == 1) begin
               test_pin = 1'b1; wait_neg(4);
            end
            release_check((exp == BOOT) ? "R5 R4 sweep boot" : "R6 sweep vector", exp);
            check("R9 debug during release", debug_sel, logic'(fin));
            rst_pin_n = 1'b0; test_pin = 1'b0;
            wait_neg(4);
         end
      end

      // R2: edges while reset pin high are ignored
      rst_pin_n = 1'b1; releases++;
      wait_neg(5);
      check("R8 vector after plain release", start_addr, VEC);
      test_pulse(); test_pulse(); test_pulse();
      check("R8 addr unchanged by test edges", start_addr, VEC);
      rst_pin_n = 1'b0; wait_neg(4);
      test_pin = 1'b1; wait_neg(4);
      release_check("R2 high-phase edges ignored", VEC);
      rst_pin_n = 1'b0; test_pin = 1'b0; wait_neg(4);

      // R3: count from previous low phase is cleared
      test_pulse(); test_pulse();
      release_check("R3 first phase test low", VEC);
      rst_pin_n = 1'b0; wait_neg(4);
      test_pin = 1'b1; wait_neg(4);
      release_check("R3 count cleared between phases", VEC);

      // R5 boot again, then R8 hold across debug activity
      rst_pin_n = 1'b0; test_pin = 1'b0; wait_neg(4);
      test_pulse();
      test_pin = 1'b1; wait_neg(4);
      release_check("R5 boot entry", BOOT);
      test_pin = 1'b0; wait_neg(3);
      test_pulse();
      check("R8 boot addr held", start_addr, BOOT);
      check("R9 debug released", debug_sel, 1'b0);

      wait_neg(4);
      check("R7 strobes equal releases", pulses_seen, releases);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule